// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a slave on a two-wire serial bus (I2C compatible) that serves a byte-wide memory array of 4096 locations. A fast system clock oversamples the bus clock and data lines. The block finds bus conditions, decodes a device-select byte and a two-byte location pointer, and then either gathers write data or streams read data. It drives the data line only through an open-drain enable: a 1 pulls the line low, and a 0 releases it.

Write data first collects in a 32-entry page buffer. The buffer reaches the array only when the master closes the transfer with a stop condition. A counter then stands in for the self-timed programming interval. While that counter runs, the slave answers nothing. Three strap inputs select one of eight device numbers on a shared bus. A protect input turns write commands into acknowledged no-ops. Reads can fetch from a given pointer, continue from the current pointer, or stream any number of successive bytes.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the slave releases the data line (`sda_oe_o` = 0).
- R2: A byte write (select byte `1010 s2 s1 s0 0`, pointer high byte, pointer low byte, one data byte, stop) is acknowledged on every byte. A later random read of that location returns the byte.
- R3: A select byte whose top seven bits differ from `1010` followed by the strap value gets no acknowledge. The slave stays silent for every byte until the next start, and nothing it received is written.
- R4: Up to 32 data bytes in one write land at successive locations and read back in order.
- R5: During a write, the pointer's low 5 bits step and wrap within the 32-byte page, so byte 3 written from page offset 30 lands at offset 0 of the same page.
- R6: For WR_CYCLES clocks after a committing stop, the select byte is not acknowledged. Afterwards it is acknowledged again, and the committed data is present.
- R7: With `wp_i` high at the stop, every write byte is still acknowledged, but the array is left unchanged.
- R8: A repeated start in place of a stop discards the buffered write bytes.
- R9: Sequential reads advance the pointer by one per byte and wrap from 4095 to 0. A read with no pointer phase starts one past the last byte read.
- R10: When the master does not acknowledge a read byte, the slave releases the data line and returns to idle.
- R11: The top 4 bits of the pointer high byte are ignored.
- R12: The slave changes its data-line drive only while the bus clock is low. Its acknowledge is held low for the whole high phase of the ninth clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| strap_i | input | 3 | Device-number straps compared with select bits 3..1 |
| wp_i | input | 1 | Write protect, sampled at the stop condition |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |

## Verification
The bench targets the page-offset wrap, the array-top wrap of a streaming read, and the pointer reuse of a read that has no pointer phase. A design that wrapped across the whole array during a page write, or that lost the pointer between transfers, would return the wrong bytes at those spots. It also sends a select byte into the busy window, where a design that ignored its timer would acknowledge. It ends a write with a repeated start, where a design that committed on any bus condition would overwrite the data. It holds the protect pin high through a write, where a design that blocked the acknowledge instead of the commit would show missing acknowledges. Finally, it checks that the drive is released after a master's no-acknowledge, which a design that kept streaming would fail.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_RDAT
  } eep_state_t;

  localparam logic [3:0] EEP_DEV_ID = 4'b1010;
endpackage

// File: rtl/eep_line_sync.sv
module eep_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES:0] scl_sh;
  logic [STAGES:0] sda_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  logic scl_p, sda_p;
  assign scl_s    = scl_sh[STAGES-1];
  assign sda_s    = sda_sh[STAGES-1];
  assign scl_p    = scl_sh[STAGES];
  assign sda_p    = sda_sh[STAGES];
  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_o  = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_o   = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
  parameter int CYCLES = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic go_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (go_i)       cnt <= CW'(CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy_o = (cnt != '0);
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int AW = 12,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear_i,
  input  logic          put_i,
  input  logic [PW-1:0] slot_i,
  input  logic [7:0]    byte_i,
  input  logic          go_i,
  input  logic [AW-PW-1:0] page_i,
  output logic          any_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o
);
  localparam int SLOTS = 1 << PW;

  logic [7:0]       pg [SLOTS];
  logic [SLOTS-1:0] valid;
  logic             active;
  logic [PW-1:0]    idx;
  logic [AW-PW-1:0] base;

  always_ff @(posedge clk) begin
    if (put_i && !active) pg[slot_i] <= byte_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= '0;
      active <= 1'b0;
      idx    <= '0;
      base   <= '0;
    end else if (active) begin
      idx <= idx + 1'b1;
      if (idx == PW'(SLOTS - 1)) begin
        active <= 1'b0;
        valid  <= '0;
      end
    end else if (go_i) begin
      active <= 1'b1;
      idx    <= '0;
      base   <= page_i;
    end else if (clear_i) begin
      valid <= '0;
    end else if (put_i) begin
      valid[slot_i] <= 1'b1;
    end
  end

  assign any_o   = |valid;
  assign we_o    = active & valid[idx];
  assign waddr_o = {base, idx};
  assign wdata_o = pg[idx];

  // R4
  go_idle_chk: assert property (@(posedge clk) disable iff (rst)
    go_i |-> !active);
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W      = 12,
  parameter int PAGE_W      = 5,
  parameter int WR_CYCLES   = 250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);
  import eep_pkg::*;

  localparam int HI_W = ADDR_W - 8;

  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;

  eep_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  eep_state_t        st;
  logic [3:0]        bitcnt;
  logic [7:0]        rx, tx;
  logic [ADDR_W-1:0] ptr;
  logic [HI_W-1:0]   ahi;
  logic              rw_q, mack, sda_oe_q;
  logic [7:0]        rd_q;
  logic              wr_busy;

  logic              pb_put, pb_go, pb_any, mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [7:0]        mem_wdata;

  assign pb_put = scl_fall && !start && !stop && st == ST_WDAT && bitcnt == 4'd8;
  assign pb_go  = stop && st == ST_WDAT && pb_any && !wp_i;

  eep_page_buf #(.AW(ADDR_W), .PW(PAGE_W)) u_page (
    .clk(clk), .rst(rst), .clear_i(start), .put_i(pb_put),
    .slot_i(ptr[PAGE_W-1:0]), .byte_i(rx), .go_i(pb_go),
    .page_i(ptr[ADDR_W-1:PAGE_W]), .any_o(pb_any),
    .we_o(mem_we), .waddr_o(mem_waddr), .wdata_o(mem_wdata)
  );

  eep_array #(.AW(ADDR_W), .DW(8)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(ptr), .rdata(rd_q)
  );

  eep_wr_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .go_i(pb_go), .busy_o(wr_busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      rx       <= '0;
      tx       <= '0;
      ptr      <= '0;
      ahi      <= '0;
      rw_q     <= 1'b0;
      mack     <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (start) begin
      st       <= ST_CTRL;
      bitcnt   <= '0;
      sda_oe_q <= 1'b0;
    end else if (stop) begin
      st       <= ST_IDLE;
      bitcnt   <= '0;
      sda_oe_q <= 1'b0;
    end else if (st != ST_IDLE) begin
      if (scl_rise) begin
        if (bitcnt < 4'd8) begin
          if (st != ST_RDAT) rx <= {rx[6:0], sda_s};
        end else if (bitcnt == 4'd8 && st == ST_RDAT) begin
          mack <= !sda_s;
          ptr  <= ptr + 1'b1;
        end
        if (bitcnt != 4'd9) bitcnt <= bitcnt + 1'b1;
      end else if (scl_fall) begin
        if (bitcnt == 4'd8) begin
          case (st)
            ST_CTRL: begin
              if (rx[7:1] == {EEP_DEV_ID, strap_i} && !wr_busy) begin
                sda_oe_q <= 1'b1;
                rw_q     <= rx[0];
              end else begin
                st <= ST_IDLE;
              end
            end
            ST_AHI: begin
              ahi      <= rx[HI_W-1:0];
              sda_oe_q <= 1'b1;
            end
            ST_ALO: begin
              ptr      <= {ahi, rx};
              sda_oe_q <= 1'b1;
            end
            ST_WDAT: begin
              ptr      <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
              sda_oe_q <= 1'b1;
            end
            ST_RDAT: sda_oe_q <= 1'b0;
            default: ;
          endcase
        end else if (bitcnt == 4'd9) begin
          bitcnt   <= '0;
          sda_oe_q <= 1'b0;
          case (st)
            ST_CTRL: begin
              if (rw_q) begin
                st       <= ST_RDAT;
                tx       <= rd_q;
                sda_oe_q <= !rd_q[7];
              end else begin
                st <= ST_AHI;
              end
            end
            ST_AHI: st <= ST_ALO;
            ST_ALO: st <= ST_WDAT;
            ST_RDAT: begin
              if (mack) begin
                tx       <= rd_q;
                sda_oe_q <= !rd_q[7];
              end else begin
                st <= ST_IDLE;
              end
            end
            default: ;
          endcase
        end else if (st == ST_RDAT && bitcnt != 4'd0) begin
          tx       <= {tx[6:0], 1'b0};
          sda_oe_q <= !tx[6];
        end
      end
    end
  end

  assign sda_oe_o = sda_oe_q;

  // R12
  drive_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe_q) |-> !scl_s);

  // R6
  ctrl_ack_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_CTRL && $rose(sda_oe_q)) |-> !wr_busy);

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe_q);

  // R7
  wp_commit_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_busy) |-> !$past(wp_i));
endmodule

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam int WR = 600;
  localparam int H  = 20;
  localparam int Q  = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] wbuf [32];
  logic [7:0] rbuf [32];

  always #10 clk = ~clk;
  assign sda_line = m_sda & ~sda_oe;

  i2c_eeprom_slave #(.WR_CYCLES(WR)) u_i2c_eeprom_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_line),
    .strap_i(STRAP), .wp_i(wp), .sda_oe_o(sda_oe)
  );

  task automatic hcyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; hcyc(H);
    m_scl = 1'b1; hcyc(H);
    m_sda = 1'b0; hcyc(H);
    m_scl = 1'b0; hcyc(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hcyc(H);
    m_scl = 1'b1; hcyc(H);
    m_sda = 1'b1; hcyc(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; hcyc(H);
      m_scl = 1'b1; hcyc(H);
      m_scl = 1'b0; hcyc(Q);
    end
    m_sda = 1'b1; hcyc(H);
    m_scl = 1'b1; hcyc(Q);
    ack = !sda_line;
    hcyc(H - Q);
    m_scl = 1'b0; hcyc(Q);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] d);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hcyc(H);
      m_scl = 1'b1; hcyc(Q);
      d[i] = sda_line;
      hcyc(H - Q);
      m_scl = 1'b0;
    end
    hcyc(Q);
    m_sda = give_ack ? 1'b0 : 1'b1;
    hcyc(H - Q);
    m_scl = 1'b1; hcyc(H);
    m_scl = 1'b0; hcyc(Q);
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [15:0] a, input int n, output bit all_ack);
    bit ak;
    all_ack = 1'b1;
    bus_start();
    send_byte(SEL_W, ak); all_ack &= ak;
    send_byte(a[15:8], ak); all_ack &= ak;
    send_byte(a[7:0], ak); all_ack &= ak;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ak); all_ack &= ak;
    end
    bus_stop();
  endtask

  task automatic do_read(input logic [15:0] a, input int n, output bit all_ack);
    bit ak;
    all_ack = 1'b1;
    bus_start();
    send_byte(SEL_W, ak); all_ack &= ak;
    send_byte(a[15:8], ak); all_ack &= ak;
    send_byte(a[7:0], ak); all_ack &= ak;
    bus_start();
    send_byte(SEL_R, ak); all_ack &= ak;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    check(sda_oe == 1'b0, "R1", int'(sda_oe), 0);
  endtask

  task automatic t_byte_write();
    bit ok;
    wbuf[0] = 8'h5C;
    do_write(16'h0123, 1, ok);
    check(ok, "R2", int'(ok), 1);
    hcyc(WR + 40);
    do_read(16'h0123, 1, ok);
    check(ok, "R2", int'(ok), 1);
    check(rbuf[0] == 8'h5C, "R2", int'(rbuf[0]), 'h5C);
  endtask

  task automatic t_mismatch();
    bit ak, ok;
    bus_start();
    send_byte(8'hA0, ak);
    check(!ak, "R3", int'(ak), 0);
    send_byte(8'h01, ak);
    check(!ak, "R3", int'(ak), 0);
    send_byte(8'h23, ak);
    send_byte(8'h99, ak);
    check(!ak, "R3", int'(ak), 0);
    bus_stop();
    hcyc(WR + 40);
    do_read(16'h0123, 1, ok);
    check(rbuf[0] == 8'h5C, "R3", int'(rbuf[0]), 'h5C);
  endtask

  task automatic t_busy();
    bit ak, ok;
    wbuf[0] = 8'h77;
    do_write(16'h0200, 1, ok);
    bus_start();
    send_byte(SEL_W, ak);
    check(!ak, "R6", int'(ak), 0);
    bus_stop();
    hcyc(WR + 40);
    bus_start();
    send_byte(SEL_W, ak);
    check(ak, "R6", int'(ak), 1);
    bus_stop();
    do_read(16'h0200, 1, ok);
    check(rbuf[0] == 8'h77, "R6", int'(rbuf[0]), 'h77);
  endtask

  task automatic t_page();
    bit ok;
    int errs = 0;
    for (int i = 0; i < 32; i++) wbuf[i] = 8'(i * 3 + 1);
    do_write(16'h0400, 32, ok);
    check(ok, "R4", int'(ok), 1);
    hcyc(WR + 40);
    do_read(16'h0400, 32, ok);
    for (int i = 0; i < 32; i++) begin
      check(rbuf[i] == 8'(i * 3 + 1), "R4", int'(rbuf[i]), i * 3 + 1);
      if (rbuf[i] != 8'(i * 3 + 1)) errs++;
    end
  endtask

  task automatic t_wrap();
    bit ok;
    wbuf[0] = 8'hA1; wbuf[1] = 8'hA2; wbuf[2] = 8'hA3;
    do_write(16'h041E, 3, ok);
    hcyc(WR + 40);
    do_read(16'h041E, 2, ok);
    check(rbuf[0] == 8'hA1, "R5", int'(rbuf[0]), 'hA1);
    check(rbuf[1] == 8'hA2, "R5", int'(rbuf[1]), 'hA2);
    do_read(16'h0400, 2, ok);
    check(rbuf[0] == 8'hA3, "R5", int'(rbuf[0]), 'hA3);
    check(rbuf[1] == 8'h04, "R5", int'(rbuf[1]), 'h04);
  endtask

  task automatic t_protect();
    bit ok;
    wp = 1'b1;
    wbuf[0] = 8'h11;
    do_write(16'h0123, 1, ok);
    check(ok, "R7", int'(ok), 1);
    wp = 1'b0;
    hcyc(WR + 40);
    do_read(16'h0123, 1, ok);
    check(rbuf[0] == 8'h5C, "R7", int'(rbuf[0]), 'h5C);
  endtask

  task automatic t_restart();
    bit ak, ok;
    bus_start();
    send_byte(SEL_W, ak);
    send_byte(8'h01, ak);
    send_byte(8'h23, ak);
    send_byte(8'h66, ak);
    do_read(16'h0123, 1, ok);
    check(ok, "R8", int'(ok), 1);
    hcyc(WR + 40);
    do_read(16'h0123, 1, ok);
    check(rbuf[0] == 8'h5C, "R8", int'(rbuf[0]), 'h5C);
  endtask

  task automatic t_top_wrap();
    bit ak, ok;
    logic [7:0] d;
    wbuf[0] = 8'hE7;
    do_write(16'h0FFF, 1, ok);
    hcyc(WR + 40);
    wbuf[0] = 8'h42; wbuf[1] = 8'h43;
    do_write(16'h0000, 2, ok);
    hcyc(WR + 40);
    do_read(16'h0FFF, 2, ok);
    check(rbuf[0] == 8'hE7, "R9", int'(rbuf[0]), 'hE7);
    check(rbuf[1] == 8'h42, "R9", int'(rbuf[1]), 'h42);
    bus_start();
    send_byte(SEL_R, ak);
    recv_byte(1'b0, d);
    hcyc(H);
    check(sda_oe == 1'b0, "R10", int'(sda_oe), 0);
    bus_stop();
    check(d == 8'h43, "R9", int'(d), 'h43);
  endtask

  task automatic t_upper_ignored();
    bit ok;
    wbuf[0] = 8'hB8;
    do_write(16'hA720, 1, ok);
    check(ok, "R11", int'(ok), 1);
    hcyc(WR + 40);
    do_read(16'h0720, 1, ok);
    check(rbuf[0] == 8'hB8, "R11", int'(rbuf[0]), 'hB8);
  endtask

  initial begin
    hcyc(10);
    rst = 1'b0;
    hcyc(5);
    t_reset();
    t_byte_write();
    t_mismatch();
    t_busy();
    t_page();
    t_wrap();
    t_protect();
    t_restart();
    t_top_wrap();
    t_upper_ignored();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule